// File: doc/BRIEF.md
# Hardware-triggered nonvolatile store controller

This block fronts a small SRAM that has a nonvolatile shadow copy. In normal operation it decodes the active-low select, write and output-enable inputs into an idle, read or write cycle on the working array. A single active-low request line, shared with an open-drain busy indication, asks the block to save the working array into the shadow copy. The request line is passed through a two-flop synchroniser and must stay low for a minimum number of sampled cycles before it counts.

Once a request is accepted, the block asserts busy, lets an access that is still selected run on for a bounded number of cycles, and then copies the array word by word over a fixed, parameterised store interval. The copy runs only if the array has been written since the previous copy; otherwise the store is skipped. After the store completes or is skipped, the block releases busy and refuses every access until the request line returns high. A further recovery interval then passes before accesses resume. A read port on the shadow copy lets the surrounding logic see what the last save captured.

Top module: `nvsram_store_ctrl`

## Requirements
- R1: With `ce_n` high, `dout_en` is 0 and no write reaches the array, whatever `we_n` and `din` carry.
- R2: With `ce_n` low, `we_n` high and `oe_n` low, `dout_en` is 1 and `dout` equals the array word at `addr` in the same cycle. With `oe_n` high, `dout_en` is 0.
- R3: With `ce_n` and `we_n` both low, `din` is written to the array word at `addr` on the next rising edge, and `dout_en` is 0 during that cycle.
- R4: `store_req_n` is taken through two flops. A low level is accepted only after `MIN_PW` consecutive sampled low cycles. A pulse of 1 or `MIN_PW-1` clock cycles leaves `store_busy` at 0.
- R5: When `store_req_n` falls between two edges and stays low, `store_busy` rises after exactly `MIN_PW+2` rising edges.
- R6: An access that keeps `ce_n` low while busy rises goes on being served, for up to `DRAIN_CYC` cycles, until `ce_n` goes high. An access started after `ce_n` has gone high during a store is refused.
- R7: If the array was written since the last copy, and `ce_n` is high when the request is accepted, `store_busy` stays high for exactly `1+STORE_CYC` cycles. Afterwards the shadow copy equals the array.
- R8: A dirty flag is set by every accepted write and cleared when a copy completes. A request with no write since the last copy holds `store_busy` high for exactly 1 cycle and leaves the shadow copy unchanged.
- R9: From the end of the store until `store_req_n` rises, reads give `dout_en` = 0 and writes leave the array unchanged.
- R10: After `store_req_n` rises following a store, a held read first gets `dout_en` = 1 after exactly `RECOV_CYC+3` rising edges. Every access is refused before that.
- R11: Reset clears the array, the shadow copy and the dirty flag, and leaves `store_busy` at 0.
- R12: `nv_q` shows the shadow word at `addr` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Active-low chip select |
| we_n | input | 1 | Active-low write enable |
| oe_n | input | 1 | Active-low output enable |
| addr | input | AW | Word address |
| din | input | DW | Write data |
| dout | output | DW | Read data, zero when not driving |
| dout_en | output | 1 | Read data valid / output driver enable |
| store_req_n | input | 1 | Level seen on the shared request/busy pin |
| store_busy | output | 1 | When 1, pulls the shared pin low (open drain) |
| nv_q | output | DW | Shadow copy word at `addr` |

## Verification
A wrong dirty flag shows at the ports as a wrong busy length at the next request. The busy pulse lasts 1 cycle when it should last `1+STORE_CYC`, or the reverse, and `nv_q` keeps stale data. Both can be seen as soon as busy falls. A sequencer stuck in the wrong state shows up in one of three ways: busy rises at the wrong edge count after the request falls, the held read gets `dout_en` at the wrong edge after release, or data written during lockout appears in a later read. The bench therefore counts edges for each of these windows. It checks array and shadow contents only after the block has returned to idle.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_DRAIN = 3'd1,
        ST_STORE = 3'd2,
        ST_LOCK  = 3'd3,
        ST_RECOV = 3'd4
    } nvs_state_e;
endpackage

// File: rtl/nvs_sync.sv
module nvs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], async_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    assign sync_out = sh_q[STAGES-1];
endmodule

// File: rtl/nvs_mem.sv
module nvs_mem #(
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          copy_en,
    input  logic [AW-1:0] copy_idx,
    output logic [DW-1:0] rdata,
    output logic [DW-1:0] nv_rdata
);
    logic [DW-1:0] arr_d [DEPTH];
    logic [DW-1:0] arr_q [DEPTH];
    logic [DW-1:0] nv_d  [DEPTH];
    logic [DW-1:0] nv_q  [DEPTH];

    always_comb begin
        arr_d = arr_q;
        nv_d  = nv_q;
        if (wr_en)   arr_d[addr]   = wdata;
        if (copy_en) nv_d[copy_idx] = arr_q[copy_idx];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                arr_q[i] <= '0;
                nv_q[i]  <= '0;
            end
        end else begin
            arr_q <= arr_d;
            nv_q  <= nv_d;
        end
    end

    assign rdata    = arr_q[addr];
    assign nv_rdata = nv_q[addr];

    // R8: a copy and a write never hit the same cycle (writes are refused in the store state)
    a_r8_no_write_during_copy: assert property (@(posedge clk) disable iff (!rst_n)
        copy_en |-> !wr_en);
endmodule

// File: rtl/nvs_seq.sv
module nvs_seq
    import nvs_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int MIN_PW    = 3,
    parameter int DRAIN_CYC = 8,
    parameter int STORE_CYC = 40,
    parameter int RECOV_CYC = 6,
    localparam int AW       = $clog2(DEPTH),
    localparam int MAXC     = (STORE_CYC > DRAIN_CYC) ?
                              ((STORE_CYC > RECOV_CYC) ? STORE_CYC : RECOV_CYC) :
                              ((DRAIN_CYC > RECOV_CYC) ? DRAIN_CYC : RECOV_CYC),
    localparam int CW       = $clog2(((MAXC > DEPTH) ? MAXC : DEPTH) + 1),
    localparam int PW_W     = $clog2(MIN_PW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_low,
    input  logic          ce_n,
    input  logic          we_n,
    input  logic          oe_n,
    output logic          wr_en,
    output logic          rd_en,
    output logic          busy,
    output logic          copy_en,
    output logic [AW-1:0] copy_idx
);
    typedef struct packed {
        nvs_state_e      st;
        logic [CW-1:0]   cnt;
        logic [PW_W-1:0] pw;
        logic            dirty;
    } seq_t;

    seq_t r_q, r_d;
    logic access_en;

    always_comb begin
        access_en = (r_q.st == ST_IDLE) || ((r_q.st == ST_DRAIN) && !ce_n);
        wr_en     = access_en && !ce_n && !we_n;
        rd_en     = access_en && !ce_n && we_n && !oe_n;

        r_d       = r_q;
        r_d.dirty = r_q.dirty | wr_en;
        busy      = 1'b0;
        copy_en   = 1'b0;
        copy_idx  = r_q.cnt[AW-1:0];

        case (r_q.st)
            ST_IDLE: begin
                if (req_low) begin
                    if (r_q.pw == PW_W'(MIN_PW - 1)) begin
                        r_d.st  = ST_DRAIN;
                        r_d.cnt = '0;
                        r_d.pw  = '0;
                    end else begin
                        r_d.pw = r_q.pw + 1'b1;
                    end
                end else begin
                    r_d.pw = '0;
                end
            end
            ST_DRAIN: begin
                busy = 1'b1;
                if (ce_n || r_q.cnt == CW'(DRAIN_CYC - 1)) begin
                    r_d.cnt = '0;
                    r_d.st  = r_d.dirty ? ST_STORE : ST_LOCK;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_STORE: begin
                busy    = 1'b1;
                copy_en = (r_q.cnt < CW'(DEPTH));
                if (r_q.cnt == CW'(STORE_CYC - 1)) begin
                    r_d.st    = ST_LOCK;
                    r_d.cnt   = '0;
                    r_d.dirty = 1'b0;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_LOCK: begin
                if (!req_low) begin
                    r_d.st  = ST_RECOV;
                    r_d.cnt = '0;
                end
            end
            ST_RECOV: begin
                if (r_q.cnt == CW'(RECOV_CYC - 1)) begin
                    r_d.st  = ST_IDLE;
                    r_d.cnt = '0;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_IDLE, cnt: '0, pw: '0, dirty: 1'b0};
        else        r_q <= r_d;
    end

    // R4/R5: busy only starts while the synchronised request is low
    a_r5_busy_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_low));
    // R7: the copy phase is only ever entered with the dirty flag set
    a_r7_store_needs_dirty: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_STORE) |-> r_q.dirty);
    // R8: the flag is clear once a copy has finished
    a_r8_dirty_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(r_q.st) == ST_STORE && r_q.st == ST_LOCK) |-> !r_q.dirty);
    // R9/R10: no access is honoured during lockout or recovery
    a_r9_lock_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_LOCK || r_q.st == ST_RECOV) |-> (!wr_en && !rd_en));
    a_r10_recov_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_RECOV) |-> (r_q.cnt < CW'(RECOV_CYC)));
    // R6: the drain window never exceeds its limit
    a_r6_drain_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_DRAIN) |-> (r_q.cnt < CW'(DRAIN_CYC)));
endmodule

// File: rtl/nvsram_store_ctrl.sv
module nvsram_store_ctrl #(
    parameter int DW        = 8,
    parameter int DEPTH     = 16,
    parameter int MIN_PW    = 3,
    parameter int DRAIN_CYC = 8,
    parameter int STORE_CYC = 40,   // must be >= DEPTH
    parameter int RECOV_CYC = 6,
    localparam int AW       = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          we_n,
    input  logic          oe_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          dout_en,
    input  logic          store_req_n,
    output logic          store_busy,
    output logic [DW-1:0] nv_q
);
    logic          req_s;
    logic          wr_en, rd_en, copy_en;
    logic [AW-1:0] copy_idx;
    logic [DW-1:0] rdata;

    nvs_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(store_req_n), .sync_out(req_s)
    );

    nvs_seq #(
        .DEPTH(DEPTH), .MIN_PW(MIN_PW), .DRAIN_CYC(DRAIN_CYC),
        .STORE_CYC(STORE_CYC), .RECOV_CYC(RECOV_CYC)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .req_low(!req_s),
        .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .wr_en(wr_en), .rd_en(rd_en), .busy(store_busy),
        .copy_en(copy_en), .copy_idx(copy_idx)
    );

    nvs_mem #(.DW(DW), .DEPTH(DEPTH)) u_mem (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(din),
        .copy_en(copy_en), .copy_idx(copy_idx), .rdata(rdata), .nv_rdata(nv_q)
    );

    assign dout_en = rd_en;
    assign dout    = rd_en ? rdata : '0;

    // R1: deselected means the data driver is off
    a_r1_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |-> !dout_en);
    // R3: a write cycle never drives data
    a_r3_write_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !we_n) |-> !dout_en);
endmodule

// File: tb/nvsram_store_ctrl_tb.sv
`timescale 1ns/1ps
module nvsram_store_ctrl_tb;
    localparam int DW = 8, DEPTH = 16, AW = 4;
    localparam int MIN_PW = 3, DRAIN_CYC = 8, STORE_CYC = 40, RECOV_CYC = 6;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout, nv_q;
    logic dout_en, store_busy;
    logic ext_low = 1'b0;
    logic pin;

    int checks = 0, errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;
    assign pin = (ext_low || store_busy) ? 1'b0 : 1'b1;

    nvsram_store_ctrl #(
        .DW(DW), .DEPTH(DEPTH), .MIN_PW(MIN_PW), .DRAIN_CYC(DRAIN_CYC),
        .STORE_CYC(STORE_CYC), .RECOV_CYC(RECOV_CYC)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din), .dout(dout), .dout_en(dout_en),
        .store_req_n(pin), .store_busy(store_busy), .nv_q(nv_q)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // {ce_n, we_n, oe_n, addr, din, exp_en, exp_dout}
    localparam int VW = 3 + AW + DW + 1 + DW;
    localparam int NV = 9;
    localparam logic [VW-1:0] VEC [NV] = '{
        {3'b000, 4'h3, 8'h5A, 1'b0, 8'h00},   // R3 write
        {3'b000, 4'h7, 8'hC3, 1'b0, 8'h00},   // R3 write
        {3'b010, 4'h3, 8'h00, 1'b1, 8'h5A},   // R2 read
        {3'b010, 4'h7, 8'h00, 1'b1, 8'hC3},   // R2 read
        {3'b011, 4'h3, 8'h00, 1'b0, 8'h00},   // R2 oe high
        {3'b100, 4'h3, 8'hFF, 1'b0, 8'h00},   // R1 deselected write attempt
        {3'b110, 4'h3, 8'h00, 1'b0, 8'h00},   // R1 deselected read
        {3'b010, 4'h3, 8'h00, 1'b1, 8'h5A},   // R1 array unchanged
        {3'b010, 4'h9, 8'h00, 1'b1, 8'h00}    // R2 untouched word
    };

    task automatic idle_bus();
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic read_word(input logic [AW-1:0] a, input int exp, input string req);
        @(negedge clk);
        ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b0; addr = a;
        #1;
        chk(req, dout_en, 1);
        chk(req, dout, exp);
        idle_bus();
    endtask

    // pin falls at a negedge; count rising edges until busy is seen
    task automatic edges_to_busy(output int n);
        n = 0;
        while (!store_busy && n < 200) begin
            @(posedge clk); n++;
            @(negedge clk);
        end
    endtask

    task automatic busy_len(output int m);
        m = 1;
        forever begin
            @(negedge clk);
            if (store_busy && m < 500) m++;
            else break;
        end
    endtask

    task automatic release_and_wait(input logic [AW-1:0] a, output int n);
        @(negedge clk);
        ext_low = 1'b0;
        ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b0; addr = a;
        n = 0;
        do begin
            @(posedge clk); n++;
            @(negedge clk);
        end while (!dout_en && n < 200);
    endtask

    initial begin
        #(5ns * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n, m;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 busy", store_busy, 0);
        chk("R11 nv", nv_q, 0);
        read_word(4'h3, 8'h00, "R11 array clear");

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {ce_n, we_n, oe_n, addr, din} = VEC[i][VW-1 -: 3+AW+DW];
            #1;
            chk($sformatf("R1/R2/R3 vec%0d en", i), dout_en, VEC[i][DW]);
            if (VEC[i][DW]) chk($sformatf("R2 vec%0d data", i), dout, VEC[i][DW-1:0]);
        end
        idle_bus();
        addr = 4'h3;
        @(negedge clk);
        chk("R12 nv before store", nv_q, 0);

        // R4: short pulses are ignored
        ext_low = 1'b1; @(negedge clk); ext_low = 1'b0;
        repeat (12) begin @(negedge clk); if (store_busy) break; end
        chk("R4 1-cycle pulse", store_busy, 0);
        ext_low = 1'b1; repeat (MIN_PW - 1) @(negedge clk); ext_low = 1'b0;
        m = 0;
        repeat (12) begin @(negedge clk); if (store_busy) m = 1; end
        chk("R4 short pulse", m, 0);

        // R5 latency, R7 dirty store length
        ext_low = 1'b1;
        edges_to_busy(n);
        chk("R5 busy latency", n, MIN_PW + 2);
        busy_len(m);
        chk("R7 busy length dirty", m, 1 + STORE_CYC);
        // R9 lockout: write and read attempts refused
        ce_n = 1'b0; we_n = 1'b0; addr = 4'h3; din = 8'hEE;
        @(negedge clk);
        we_n = 1'b1; oe_n = 1'b0; #1;
        chk("R9 read refused", dout_en, 0);
        idle_bus(); addr = 4'h3; #1;
        chk("R7 shadow a3", nv_q, 8'h5A);
        addr = 4'h7; #1;
        chk("R12 shadow a7", nv_q, 8'hC3);
        release_and_wait(4'h3, n);
        chk("R10 recovery edges", n, RECOV_CYC + 3);
        chk("R9 write ignored", dout, 8'h5A);
        idle_bus();

        // R8: no writes since copy -> skipped store
        @(negedge clk);
        ext_low = 1'b1;
        edges_to_busy(n);
        busy_len(m);
        chk("R8 busy length clean", m, 1);
        release_and_wait(4'h3, n);
        chk("R10 recovery after skip", n, RECOV_CYC + 3);
        idle_bus();

        // R6: access in progress served during drain, then cut off
        @(negedge clk);
        ce_n = 1'b0; we_n = 1'b0; addr = 4'h5; din = 8'h11;
        ext_low = 1'b1;
        edges_to_busy(n);
        din = 8'h22;
        @(negedge clk);
        ce_n = 1'b1;
        @(negedge clk);
        ce_n = 1'b0; din = 8'h33;
        @(negedge clk);
        idle_bus();
        while (store_busy) @(negedge clk);
        addr = 4'h5; #1;
        chk("R6 drained write copied", nv_q, 8'h22);
        release_and_wait(4'h5, n);
        chk("R6 late write refused", dout, 8'h22);
        idle_bus();

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule